// File: doc/BRIEF.md
# HDB3 Receive Decoder with Violation Flag

This block sits behind the receive slicer of a 2.048 Mbit/s line interface, in the recovered-clock domain. Each cycle it takes one positive-rail mark bit and one negative-rail mark bit. In single-rail mode it turns them into unipolar NRZ data. If HDB3 is enabled, it removes the zero-substitution codes. A violation flag reports either plain bipolar violations or HDB3 code violations, depending on whether HDB3 is enabled.

In dual-rail mode the two rails pass through to the two data outputs. No decoding and no violation checking take place. An alternate logic polarity inverts both rails and the forwarded receive clock. A receive alarm-indication input replaces the data sent to the terminal side with all ones, in either mode.

The decoder must be able to cancel a pulse it has already accepted. To allow this, every path goes through a four-stage lookback line and then an output register. All data and flag outputs therefore have a fixed latency: a symbol sampled on a rising edge of `clk_i` appears on `data_o`/`vio_o` after the fourth rising edge that follows.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: With HDB3 disabled and single-rail selected, `data_o` is 1 for a mark on either rail and 0 for no mark, with the fixed four-edge latency. A sequence of three zeros followed by a mark is not altered.
- R2: With HDB3 disabled, a single-rail mark whose polarity equals the previous mark's polarity is a bipolar violation. Any zeros in between do not matter. `vio_o` is 1 for exactly the one cycle aligned with that bit.
- R3: Marks on both rails in the same cycle are decoded as 1 and flagged on `vio_o`. They do not change the remembered polarity of the last mark.
- R4: With HDB3 enabled, a repeated-polarity mark after exactly three zeros is a valid substitution if its polarity is opposite the last accepted one, or if it is the first since reset. It is decoded as 0 and is not flagged.
- R5: With HDB3 enabled, a repeated-polarity mark after exactly two zeros that follow a mark is a valid substitution under the same alternation rule. Both that mark and the earlier one are decoded as 0 and nothing is flagged.
- R6: With HDB3 enabled, a repeated-polarity mark is a code violation if either of these holds:
  - its polarity equals that of the last accepted substitution;
  - fewer than two zeros precede it.

  A code violation is decoded as 1, flagged on `vio_o` for one cycle, and not remembered as an accepted substitution.
- R7: In single-rail mode, `rx_ais_i` forces `data_o` to 1 from the next rising edge. `vio_o` keeps reporting violations.
- R8: In dual-rail mode, `data_o` carries the positive rail and `vio_o` the negative rail, each with the fixed latency. `hdb3_en_i` has no effect.
- R9: In dual-rail mode with `logic_mode2_i` = 1, both rail outputs are inverted (a mark is 0) and `rclk_o` is the inverse of `clk_i`. Otherwise `rclk_o` equals `clk_i`. In single-rail mode `logic_mode2_i` has no effect.
- R10: In dual-rail mode, `rx_ais_i` puts a mark on both rail outputs: level 1 in normal polarity, level 0 with `logic_mode2_i` = 1.
- R11: While `rst_ni` is low, `data_o` and `vio_o` are 0 and all polarity and zero-count history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 1 | Positive-rail mark for this bit period |
| neg_i | input | 1 | Negative-rail mark for this bit period |
| hdb3_en_i | input | 1 | Enables substitution removal and code-violation checking |
| dual_rail_i | input | 1 | 0 single-rail, 1 dual-rail pass-through |
| logic_mode2_i | input | 1 | Dual-rail inverted polarity for data and clock |
| rx_ais_i | input | 1 | Replace terminal-side data with all ones |
| data_o | output | 1 | Single-rail NRZ data, or positive rail in dual-rail mode |
| vio_o | output | 1 | Violation flag, or negative rail in dual-rail mode |
| rclk_o | output | 1 | Receive clock toward the terminal, optionally inverted |

## Verification
A wrong polarity or zero-count memory in the decoder shows up as a spurious or missing `vio_o` pulse on the first repeated-polarity mark after the fault. It also causes a wrong 0/1 on `data_o` for that mark and, in the two-zero case, for the mark three periods earlier. Both appear exactly four edges after the mark is sampled. A lookback clear at the wrong depth zeroes a neighbouring bit of the same word, so every substitution pattern is checked bit by bit across its whole span. Mode and alarm selection errors appear on the very next edge because they act at the output register.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  typedef struct packed {
    logic nrail;
    logic prail;
    logic vio;
    logic dbit;
  } lane_t;

endpackage

// File: rtl/rx_mark_classifier.sv
module rx_mark_classifier #(
  parameter int unsigned ZERO_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic hdb3_en_i,
  output logic dbit_o,
  output logic vio_o,
  output logic clr_o
);
  localparam int unsigned ZW = $clog2(ZERO_RUN + 1);
  localparam logic [ZW-1:0] ZFULL = ZW'(ZERO_RUN);
  localparam logic [ZW-1:0] ZSHORT = ZW'(ZERO_RUN - 1);

  logic [ZW-1:0] zcnt_q;
  logic have_mark_q, last_pos_q, have_v_q, last_vpos_q;
  logic both, single, same, v_ok;

  always_comb begin
    both   = pos_i & neg_i;
    single = pos_i ^ neg_i;
    same   = single & have_mark_q & (pos_i == last_pos_q);
    v_ok   = hdb3_en_i & same & (zcnt_q >= ZSHORT) &
             (~have_v_q | (pos_i != last_vpos_q));
    clr_o  = v_ok & (zcnt_q == ZSHORT);
    dbit_o = (pos_i | neg_i) & ~v_ok;
    vio_o  = both | (same & ~v_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zcnt_q      <= '0;
      have_mark_q <= 1'b0;
      last_pos_q  <= 1'b0;
      have_v_q    <= 1'b0;
      last_vpos_q <= 1'b0;
    end else if (both) begin
      zcnt_q <= '0;
    end else if (single) begin
      zcnt_q      <= '0;
      have_mark_q <= 1'b1;
      last_pos_q  <= pos_i;
      if (v_ok) begin
        have_v_q    <= 1'b1;
        last_vpos_q <= pos_i;
      end
    end else if (zcnt_q != ZFULL) begin
      zcnt_q <= zcnt_q + 1'b1;
    end
  end

  // a lone mark can only be flagged once a polarity is remembered
  a_r6_flag_needs_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vio_o && !(pos_i && neg_i)) |-> have_mark_q);

endmodule

// File: rtl/rx_lane_delay.sv
module rx_lane_delay
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned CLR_IDX = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  lane_t lane_i,
  input  logic  clr_i,
  output lane_t lane_o
);
  lane_t stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    lane_t nxt;
    if (g == 0) begin : g_head
      assign nxt = lane_i;
    end else begin : g_body
      always_comb begin
        nxt = stg_q[g-1];
        if (clr_i && (g - 1) == CLR_IDX) nxt.dbit = 1'b0;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= nxt;
    end
  end

  assign lane_o = stg_q[DEPTH-1];

  // the cancelled pulse must be a decoded mark
  a_r5_clear_hits_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> stg_q[CLR_IDX].dbit);

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned ZERO_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic hdb3_en_i,
  input  logic dual_rail_i,
  input  logic logic_mode2_i,
  input  logic rx_ais_i,
  output logic data_o,
  output logic vio_o,
  output logic rclk_o
);
  localparam int unsigned DEPTH   = ZERO_RUN + 1;
  localparam int unsigned CLR_IDX = ZERO_RUN - 1;

  logic  cls_dbit, cls_vio, cls_clr;
  lane_t lane_in, lane_out;
  logic  data_nxt, vio_nxt, inv;
  logic  data_q, vio_q;

  rx_mark_classifier #(.ZERO_RUN(ZERO_RUN)) u_cls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos_i),
    .neg_i    (neg_i),
    .hdb3_en_i(hdb3_en_i),
    .dbit_o   (cls_dbit),
    .vio_o    (cls_vio),
    .clr_o    (cls_clr)
  );

  assign lane_in = '{nrail: neg_i, prail: pos_i, vio: cls_vio, dbit: cls_dbit};

  rx_lane_delay #(.DEPTH(DEPTH), .CLR_IDX(CLR_IDX)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lane_i(lane_in),
    .clr_i (cls_clr),
    .lane_o(lane_out)
  );

  assign inv = dual_rail_i & logic_mode2_i;

  always_comb begin
    if (dual_rail_i) begin
      data_nxt = (rx_ais_i | lane_out.prail) ^ inv;
      vio_nxt  = (rx_ais_i | lane_out.nrail) ^ inv;
    end else begin
      data_nxt = rx_ais_i | lane_out.dbit;
      vio_nxt  = lane_out.vio;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      vio_q  <= 1'b0;
    end else begin
      data_q <= data_nxt;
      vio_q  <= vio_nxt;
    end
  end

  assign data_o = data_q;
  assign vio_o  = vio_q;
  assign rclk_o = clk_i ^ inv;

  a_r7_ais_single_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rx_ais_i) && !$past(dual_rail_i)) |-> data_o);

  a_r10_ais_dual_rails_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rx_ais_i) && $past(dual_rail_i)) |-> (data_o == vio_o));

endmodule

// File: tb/hdb3_rx_decoder_test.sv
module hdb3_rx_decoder_test;
  localparam time TCK = 8ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b0;
  logic hdb3_en_i = 1'b0, dual_rail_i = 1'b0, logic_mode2_i = 1'b0, rx_ais_i = 1'b0;
  logic data_o, vio_o, rclk_o;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(TCK/2) clk = ~clk;

  hdb3_rx_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .pos_i(pos_i), .neg_i(neg_i),
    .hdb3_en_i(hdb3_en_i), .dual_rail_i(dual_rail_i),
    .logic_mode2_i(logic_mode2_i), .rx_ais_i(rx_ais_i),
    .data_o(data_o), .vio_o(vio_o), .rclk_o(rclk_o)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive_sym(byte c);
    pos_i = (c == "+" || c == "*");
    neg_i = (c == "-" || c == "*");
  endtask

  // sym: + - * (both) 0 ; expected strings are per input symbol
  task automatic run_case(string req, bit hdb3, bit dual, bit m2, bit ais,
                          string sym, string exp_d, string exp_v);
    int n = sym.len();
    @(negedge clk);
    rst_ni = 1'b0;
    hdb3_en_i = hdb3; dual_rail_i = dual; logic_mode2_i = m2; rx_ais_i = ais;
    drive_sym("0");
    @(negedge clk);
    rst_ni = 1'b1;
    drive_sym(sym[0]);
    for (int k = 1; k < n + 5; k++) begin
      @(negedge clk);
      if (k == 5) check("R9", {req, " rclk level"}, rclk_o, dual & m2);
      if (k >= 5) begin
        check(req, $sformatf("%s data bit %0d", sym, k - 5), data_o, exp_d[k-5] == "1");
        check(req, $sformatf("%s vio bit %0d", sym, k - 5), vio_o, exp_v[k-5] == "1");
      end
      drive_sym(k < n ? sym[k] : "0");
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    hdb3_en_i = 1'b1; dual_rail_i = 1'b0; logic_mode2_i = 1'b0; rx_ais_i = 1'b1;
    drive_sym("+");
    @(negedge clk);
    check("R11", "data in reset", data_o, 1'b0);
    check("R11", "vio in reset", vio_o, 1'b0);
    rx_ais_i = 1'b0;
    drive_sym("0");
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    // R1 plain AMI decoding, substitution pattern untouched
    run_case("R1", 0, 0, 0, 0, "+0-+0-", "101101", "000000");
    run_case("R1", 0, 0, 0, 0, "+000+",  "10001",  "00001");
    // R2 bipolar violations
    run_case("R2", 0, 0, 0, 0, "+0+--",  "10111",  "00101");
    // R3 simultaneous marks
    run_case("R3", 0, 0, 0, 0, "+*-",    "111",    "010");
    run_case("R3", 1, 0, 0, 0, "+*-",    "111",    "010");
    // R4 three-zero substitution, alternating
    run_case("R4", 1, 0, 0, 0, "+000+-000-", "1000010000", "0000000000");
    // R5 two-zero substitution with cancelled pulse
    run_case("R5", 1, 0, 0, 0, "+-00-+00+", "100000000", "000000000");
    // R6 code violations
    run_case("R6", 1, 0, 0, 0, "+000+000+", "100000001", "000000001");
    run_case("R6", 1, 0, 0, 0, "+0+",       "101",       "001");
    run_case("R6", 1, 0, 0, 0, "-0-",       "101",       "001");
    // R7 single-rail AIS, flag still live
    run_case("R7", 0, 0, 0, 1, "+0+0",      "1111",      "0010");
    // R8 dual-rail pass-through, HDB3 ignored
    run_case("R8", 0, 1, 0, 0, "+-*0+",     "10101",     "01100");
    run_case("R8", 1, 1, 0, 0, "+000+",     "10001",     "00000");
    // R9 inverted polarity, and ignored in single-rail
    run_case("R9", 0, 1, 1, 0, "+-*0+",     "01010",     "10011");
    run_case("R9", 0, 0, 1, 0, "+0+-",      "1011",      "0010");
    // R10 dual-rail AIS
    run_case("R10", 0, 1, 0, 1, "+0-",      "111",       "111");
    run_case("R10", 0, 1, 1, 1, "+0-",      "000",       "000");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule